// File: doc/BRIEF.md
# Single-Cycle Three-Format RISC Core

This block is a minimal 32-bit processor core that retires one instruction on every clock edge. On each cycle it presents the program counter on an instruction-fetch port and takes the returned word in the same cycle. It splits that word into its opcode, register and immediate fields, then reads two operands from a 32-entry register file and computes a result. The result is written back at the closing clock edge.

Seven operations are supported:

- register subtraction
- signed and unsigned immediate addition
- OR with a zero-filled immediate
- upper-half immediate load
- word load
- word store

A load or store address is the base register plus a sign-extended 16-bit offset. The data port has a combinational read and a write that takes effect at the clock edge. Every other encoding leaves all state unchanged. There are no branches, so the program counter only counts upward.

The core is meant to be placed beside two word-wide memories. A 32-bit constant is built with an upper-half load followed by an OR of the lower half.

Top module: `risc_lite_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. After each clock edge with `rst_n` high, the program counter advances by 4. `imem_addr` always equals the program counter.
- R2: A word with opcode [31:26] = 0 and function [5:0] = 34 writes register rd [15:11] with rs [25:21] minus rt [20:16], modulo 2^32.
- R3: Opcode 8 writes rt with rs plus the 16-bit immediate [15:0] sign-extended from bit 15. For example, the word 0x21840021 puts reg12 + 33 into register 4.
- R4: Opcode 9 writes rt with rs plus the immediate zero-extended.
- R5: Opcode 13 writes rt with rs OR the zero-extended immediate.
- R6: Opcode 15 writes rt with the immediate in bits [31:16] and zeros in bits [15:0]. Following it with opcode 13 on the same register yields a full 32-bit constant such as 0x1B234567.
- R7: Opcode 35 drives `dmem_addr` with rs + sign-extended offset and writes rt with `dmem_rdata`. Negative offsets are allowed.
- R8: Opcode 43 raises `dmem_we` for that cycle and drives `dmem_addr` with rs + sign-extended offset and `dmem_wdata` with rt. It writes no register. `dmem_we` is low for every other instruction.
- R9: Register 0 always reads as zero, and any write aimed at it is discarded.
- R10: Any opcode other than 0, 8, 9, 13, 15, 35 and 43, and any opcode-0 word whose function field is not 34, changes no register and no memory.
- R11: A register written by one instruction gives the new value to the very next instruction that reads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory at the clock edge |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` in the same cycle |

## Verification
The overlap that matters is a register write-back at the end of one instruction against the operand read of the next instruction that names the same register. Two cases are covered: a store placed directly after each producer, and a load whose loaded value is stored immediately. This judges whether forwarding through the register file is correct. A behavioural model in the bench steps one instruction per clock, keeping its own register and memory arrays. Each cycle it compares the fetch address, the store strobe, and the address and data of each access. A mismatch is charged to the requirement that produced the compared value. Writes aimed at register 0 and undefined encodings are followed by stores that expose the register left untouched.

// File: rtl/risc_lite_pkg.sv
// Package risc_lite_pkg
// Shared widths, fixed instruction encodings and decoded-control types
// for the single-cycle core. Assumes the 32-bit three-format layout.
package risc_lite_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);
    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDS  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ADDZ  = 6'd9;
    localparam logic [OPC_W-1:0] OPC_ORZ   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_UPPER = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
    localparam logic [FN_W-1:0]  FN_SUB    = 6'd34;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2,
        ALU_HI  = 2'd3
    } alu_op_e;

    typedef enum logic {
        EXT_SIGN = 1'b0,
        EXT_ZERO = 1'b1
    } ext_mode_e;

    typedef struct packed {
        logic      known;
        logic      reg_we;
        logic      dst_rd;
        logic      use_imm;
        ext_mode_e ext;
        alu_op_e   op;
        logic      ld;
        logic      st;
    } ctrl_t;

endpackage

// File: rtl/risc_lite_decode.sv
// Module risc_lite_decode
// Splits an instruction word into fields and produces the control bundle.
// Purely combinational. Assumes fixed field positions: opcode at the top,
// source registers next, destination/shift/function below them.
module risc_lite_decode
    import risc_lite_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output logic [RIDX_W-1:0] rs_idx,
    output logic [RIDX_W-1:0] rt_idx,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [IMM_W-1:0]  imm,
    output ctrl_t             ctrl
);
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RS_LSB  = OPC_LSB - RIDX_W;
    localparam int RT_LSB  = RS_LSB - RIDX_W;
    localparam int RD_LSB  = RT_LSB - RIDX_W;

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;

    // Field extraction at fixed positions.
    always_comb begin
        opc    = instr[XLEN-1:OPC_LSB];
        rs_idx = instr[OPC_LSB-1:RS_LSB];
        rt_idx = instr[RS_LSB-1:RT_LSB];
        rd_idx = instr[RT_LSB-1:RD_LSB];
        imm    = instr[IMM_W-1:0];
        fn     = instr[FN_W-1:0];
    end

    // Opcode / function table to control bundle; unlisted codes stay quiet.
    always_comb begin
        ctrl         = '0;
        ctrl.ext     = EXT_SIGN;
        ctrl.op      = ALU_ADD;
        unique case (opc)
            OPC_REG: begin
                if (fn == FN_SUB) begin
                    ctrl.known  = 1'b1;
                    ctrl.reg_we = 1'b1;
                    ctrl.dst_rd = 1'b1;
                    ctrl.op     = ALU_SUB;
                end
            end
            OPC_ADDS: begin
                ctrl.known   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OPC_ADDZ: begin
                ctrl.known   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.ext     = EXT_ZERO;
            end
            OPC_ORZ: begin
                ctrl.known   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.ext     = EXT_ZERO;
                ctrl.op      = ALU_OR;
            end
            OPC_UPPER: begin
                ctrl.known   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.op      = ALU_HI;
            end
            OPC_LOAD: begin
                ctrl.known   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.ld      = 1'b1;
            end
            OPC_STORE: begin
                ctrl.known   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.st      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/risc_lite_regfile.sv
// Module risc_lite_regfile
// Two combinational read ports, one write port taken at the clock edge.
// Assumes entry 0 is hard zero; synchronous active-low reset clears all.
module risc_lite_regfile
    import risc_lite_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] raddr_a,
    input  logic [$clog2(N)-1:0] raddr_b,
    output logic [W-1:0]         rdata_a,
    output logic [W-1:0]         rdata_b,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata
);
    localparam int AW = $clog2(N);

    logic [W-1:0] regs [N];

    // Write port: reset clears, slot 0 never takes a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (waddr != AW'(0))) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports: slot 0 forced to zero.
    always_comb begin
        rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];
    end

    // R11: a write to a nonzero slot is readable on the next cycle.
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != AW'(0)) |=> regs[$past(waddr)] == $past(wdata));

    // R9: a write aimed at slot 0 leaves the slot-0 read at zero.
    a_r9_zero_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(0) && raddr_a == AW'(0)) |=> (raddr_a != AW'(0) || rdata_a == '0));
endmodule

// File: rtl/risc_lite_alu.sv
// Module risc_lite_alu
// Result datapath: add, subtract, OR and upper-half placement.
// Combinational; assumes the B operand is already selected and extended.
module risc_lite_alu
    import risc_lite_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [IW-1:0]  imm,
    output logic [W-1:0]   y
);
    localparam int LOW_W = W - IW;

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            ALU_HI:  y = {imm, {LOW_W{1'b0}}};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/risc_lite_core.sv
// Module risc_lite_core
// Single-cycle core: fetch at pc, decode, read, execute, access memory and
// write back, all between two clock edges. Assumes both memories answer a
// read combinationally and the data memory writes at the clock edge.
module risc_lite_core
    import risc_lite_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [31:0]     imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [31:0]     dmem_addr,
    output logic [31:0]     dmem_wdata,
    output logic            dmem_we,
    input  logic [31:0]     dmem_rdata
);
    localparam int          EXT_W = XLEN - IMM_W;
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(XLEN / 8);

    logic [XLEN-1:0]   pc;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wb_idx;
    logic [IMM_W-1:0]  imm;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, op_b, alu_y, wb_val;

    // Program counter: clear on reset, then fixed step.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + PC_STEP;
    end

    assign imem_addr = pc;

    risc_lite_decode u_dec (
        .instr  (imem_rdata),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .imm    (imm),
        .ctrl   (ctrl)
    );

    // Destination pick and write-back source.
    always_comb begin
        wb_idx = ctrl.dst_rd ? rd_idx : rt_idx;
        wb_val = ctrl.ld ? dmem_rdata : alu_y;
    end

    risc_lite_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .raddr_a (rs_idx),
        .raddr_b (rt_idx),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .we      (ctrl.reg_we),
        .waddr   (wb_idx),
        .wdata   (wb_val)
    );

    // Immediate extension and B operand select.
    always_comb begin
        if (ctrl.ext == EXT_ZERO) imm_ext = {{EXT_W{1'b0}}, imm};
        else                      imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        op_b = ctrl.use_imm ? imm_ext : rt_val;
    end

    risc_lite_alu #(.W(XLEN), .IW(IMM_W)) u_alu (
        .op  (ctrl.op),
        .a   (rs_val),
        .b   (op_b),
        .imm (imm),
        .y   (alu_y)
    );

    // Data port drive; strobe held low during reset.
    always_comb begin
        dmem_addr  = alu_y;
        dmem_wdata = rt_val;
        dmem_we    = ctrl.st & rst_n;
    end

    // R1: fixed step after each edge out of reset.
    a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> imem_addr == $past(imem_addr) + PC_STEP);

    // R8: a store never writes back.
    a_r8_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !ctrl.reg_we);

    // R7 / R8: load and store are exclusive.
    a_r7_access_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.ld, ctrl.st}));

    // R10: undefined encodings touch nothing.
    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.known |-> (!ctrl.reg_we && !dmem_we && !ctrl.ld));

    // R6: upper-half load leaves the low half clear.
    a_r6_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.op == ALU_HI) |-> alu_y[EXT_W-1:0] == '0);

    // R9: source index 0 always yields zero.
    a_r9_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_idx == '0) |-> rs_val == '0);
endmodule

// File: tb/risc_lite_core_bench.sv
// Bench for risc_lite_core: a behavioural instruction-level model steps
// once per clock and is compared with the ports at every falling edge.
module risc_lite_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] prog [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state.
    logic [31:0] mreg [32];
    string       mtag [32];
    logic [31:0] mmem [64];
    logic [31:0] mpc;

    always #5 clk = ~clk;

    risc_lite_core u_risc_lite_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = prog[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] ei(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] er(int rs, int rt, int rd, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(int dst, logic [31:0] v, string tag);
        if (dst == 0) mtag[0] = "R9";
        else begin
            mreg[dst] = v;
            mtag[dst] = tag;
        end
    endtask

    // One model instruction: compare ports, then advance model state.
    task automatic step();
        logic [31:0] ins, sx, zx, addr;
        int op, rs, rt, rd, fn;
        ins = prog[mpc[7:2]];
        op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); fn = int'(ins[5:0]);
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0, ins[15:0]};
        addr = mreg[rs] + sx;
        chk("R1", "imem_addr", imem_addr, mpc);
        chk("R8", "dmem_we", {31'd0, dmem_we}, {31'd0, op == 43});
        case (op)
            0: if (fn == 34) wr(rd, mreg[rs] - mreg[rt], "R2");
               else if (rd != 0) mtag[rd] = "R10";
            8:  wr(rt, mreg[rs] + sx, "R3");
            9:  wr(rt, mreg[rs] + zx, "R4");
            13: wr(rt, mreg[rs] | zx, (mtag[rs] == "R6") ? "R6" : "R5");
            15: wr(rt, {ins[15:0], 16'h0}, "R6");
            35: begin
                chk("R7", "dmem_addr", dmem_addr, addr);
                wr(rt, mmem[addr[7:2]], "R7");
            end
            43: begin
                chk("R8", "dmem_addr", dmem_addr, addr);
                chk(mtag[rt], "dmem_wdata", dmem_wdata, mreg[rt]);
                mmem[addr[7:2]] = mreg[rt];
            end
            default: if (rt != 0) mtag[rt] = "R10";
        endcase
        mpc = mpc + 32'd4;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            prog[i] = 32'h0;
            dmem[i] = 32'h0;
            mmem[i] = 32'h0;
        end
        for (int i = 0; i < 32; i++) begin
            mreg[i] = 32'h0;
            mtag[i] = "R9";
        end
        // R3 and R11: each producer is followed at once by a store of its result.
        prog[0]  = ei(8, 0, 12, 12);
        prog[1]  = 32'h21840021;            // R3: reg4 = reg12 + 33
        prog[2]  = ei(43, 0, 4, 0);
        prog[3]  = ei(8, 0, 7, 16'hFFFB);   // R3: negative immediate
        prog[4]  = ei(43, 0, 7, 4);
        prog[5]  = ei(9, 0, 8, 16'hFFFB);   // R4: zero-extended
        prog[6]  = ei(43, 0, 8, 8);
        prog[7]  = ei(15, 0, 9, 16'h1B23);  // R6
        prog[8]  = ei(43, 0, 9, 12);
        prog[9]  = ei(13, 9, 9, 16'h4567);  // R6: full constant 0x1B234567
        prog[10] = ei(43, 0, 9, 16);
        prog[11] = ei(13, 0, 10, 16'h8001); // R5: no sign fill
        prog[12] = ei(43, 0, 10, 20);
        prog[13] = er(4, 12, 11, 34);       // R2: 45 - 12
        prog[14] = ei(43, 0, 11, 24);
        prog[15] = er(12, 4, 13, 34);       // R2: wraps below zero
        prog[16] = ei(43, 0, 13, 28);
        prog[17] = ei(35, 0, 14, 16);       // R7
        prog[18] = ei(43, 0, 14, 32);
        prog[19] = ei(8, 0, 15, 40);
        prog[20] = ei(35, 15, 16, 16'hFFE8); // R7: negative offset, addr 16
        prog[21] = ei(43, 15, 16, 16'hFFFC); // R8: negative offset, addr 36
        prog[22] = ei(8, 0, 0, 99);         // R9: write to reg0 dropped
        prog[23] = ei(43, 0, 0, 40);
        prog[24] = er(4, 12, 0, 34);        // R9
        prog[25] = ei(43, 0, 0, 44);
        prog[26] = ei(63, 4, 4, 16'h1234);  // R10: undefined opcode
        prog[27] = er(4, 4, 4, 32);         // R10: undefined function
        prog[28] = ei(43, 0, 4, 48);
        prog[29] = ei(35, 0, 17, 0);
        prog[30] = ei(43, 0, 17, 52);       // R11: loaded value stored at once

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "imem_addr in reset", imem_addr, 32'h0);
        chk("R1", "dmem_we in reset", {31'd0, dmem_we}, 32'h0);
        mpc = 32'h0;
        rst_n = 1'b1;
        for (int c = 0; c < 70; c++) begin
            #1;
            step();
            @(negedge clk);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule